// File: doc/BRIEF.md
# Staggered Tile Schedule Generator for Parallel Sparse Matrix Multiply

This block drives a group of identical sparse matrix multiply engines that together form a tiled product C = A·B. Every matrix is cut into an NB×NB grid of blocks, and each block lives in one DRAM row. Engine c owns block column c of the result. For each result block C(i,c) it walks the inner index k from 0 to NB-1 and, at each step, presents a fetch pair: block A(i,k) and block B(k,c).

The descriptor of each block comes from an external metadata table that is read combinationally. The block drives a table index, and the table answers with the block's DRAM row, size, format code and nonzero count. That descriptor is forwarded with the fetch request. A pair in which either block holds no nonzeros is not requested. At the end of every result block the block emits a completion marker.

The engines begin on different block rows, each one block further down than the previous engine, and all of them advance through the steps together. In any cycle no two engines touch the same A block or the same B block. The number of engines must not exceed NB.

Top module: `tile_sched`

## Requirements
- R1: While rst_ni is low, and afterwards until a run starts, req_valid_o and done_valid_o are all zero.
- R2: A high start_i while no run is active begins a run on the next clock, with every engine at its first result block and k = 0. start_i is ignored while a run is active.
- R3: Engine c works on result column c only. Its first result block is row c, and each later block is row (previous+1) mod NB, wrapping, for NB result blocks in all. done_col_o of engine c is always c.
- R4: Within a result block, k steps 0,1,…,NB-1 on req_k_o. The metadata index for A is row*NB+k and for B is k*NB+c. req_a_md_o and req_b_md_o carry the table words at those indices unchanged. Each word is packed as {row address[37:22], size[21:14], format[13:12], nonzero count[11:0]}.
- R5: If either block of an engine's pair has a nonzero count of 0, that engine's req_valid_o stays low for that step and the pair is never fetched.
- R6: The shared step advances on a clock only if every engine with req_valid_o high also has ready_i high. Otherwise all requests hold their row and k.
- R7: done_valid_o of an engine is high, with done_row_o equal to the result row, in exactly the cycle in which its k = NB-1 step advances. This holds whether or not the pair in that step was skipped.
- R8: In any cycle, no two engines with req_valid_o high present the same result row, so no A block and no B block is requested twice.
- R9: A run ends after NB×NB advanced steps. Each engine gives exactly NB completion markers, and all outputs are quiet afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run when idle |
| ready_i | input | NCORE | Per engine: request may be taken this cycle |
| md_a_idx_o | output | NCORE*IDX_W | Per engine: metadata index of the A block |
| md_b_idx_o | output | NCORE*IDX_W | Per engine: metadata index of the B block |
| md_a_i | input | NCORE*MD_W | Per engine: metadata word of the A block |
| md_b_i | input | NCORE*MD_W | Per engine: metadata word of the B block |
| req_valid_o | output | NCORE | Per engine: fetch pair is being requested |
| req_row_o | output | NCORE*IW | Per engine: current result block row |
| req_k_o | output | IW | Shared inner index k |
| req_a_md_o | output | NCORE*MD_W | Per engine: descriptor of the A block |
| req_b_md_o | output | NCORE*MD_W | Per engine: descriptor of the B block |
| done_valid_o | output | NCORE | Per engine: result block completed |
| done_row_o | output | NCORE*IW | Per engine: row of the completed block |
| done_col_o | output | NCORE*IW | Per engine: column of the completed block |

## Verification
The bench goes after row wrap-around for the engines that start near the bottom of the grid. A design that got this wrong would request a row past NB-1, or two engines would land on the same row, which the pairwise conflict check catches. Randomly stalled ready lines and mid-run start pulses test the hold and ignore rules. A design that let one engine run ahead, or that restarted its counters, would show shifted k values and extra or missing completion markers. A run in which every A block is empty checks two things: the markers must still arrive on the last k, and the run must still take exactly NB×NB cycles. A design that dropped markers for skipped pairs, or that collapsed empty steps, would fail here.

// File: rtl/tile_sched_pkg.sv
package tile_sched_pkg;
  parameter int ROW_W  = 16;
  parameter int SIZE_W = 8;
  parameter int FMT_W  = 2;
  parameter int NNZ_W  = 12;

  typedef struct packed {
    logic [ROW_W-1:0]  row;
    logic [SIZE_W-1:0] size;
    logic [FMT_W-1:0]  fmt;
    logic [NNZ_W-1:0]  nnz;
  } blk_md_t;

  localparam int MD_W = $bits(blk_md_t);
endpackage

// File: rtl/tile_step_ctr.sv
module tile_step_ctr #(
  parameter int NB = 4,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          adv_i,
  output logic          run_o,
  output logic [IW-1:0] t_o,
  output logic [IW-1:0] k_o,
  output logic          last_k_o
);
  localparam logic [IW-1:0] LAST = IW'(NB - 1);

  assign last_k_o = (k_o == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= 1'b0;
      t_o   <= '0;
      k_o   <= '0;
    end else if (!run_o) begin
      if (start_i) begin
        run_o <= 1'b1;
        t_o   <= '0;
        k_o   <= '0;
      end
    end else if (adv_i) begin
      if (last_k_o) begin
        k_o <= '0;
        if (t_o == LAST) run_o <= 1'b0;
        else             t_o   <= t_o + IW'(1);
      end else begin
        k_o <= k_o + IW'(1);
      end
    end
  end
endmodule

// File: rtl/tile_core_lane.sv
module tile_core_lane
  import tile_sched_pkg::*;
#(
  parameter int NB   = 4,
  parameter int CORE = 0,
  localparam int IW    = $clog2(NB),
  localparam int IDX_W = $clog2(NB * NB)
) (
  input  logic             run_i,
  input  logic [IW-1:0]    t_i,
  input  logic [IW-1:0]    k_i,
  input  logic [NNZ_W-1:0] nnz_a_i,
  input  logic [NNZ_W-1:0] nnz_b_i,
  output logic [IW-1:0]    row_o,
  output logic [IDX_W-1:0] idx_a_o,
  output logic [IDX_W-1:0] idx_b_o,
  output logic             want_o
);
  localparam logic [IW:0] CORE_V = (IW + 1)'(CORE);
  localparam logic [IW:0] NB_V   = (IW + 1)'(NB);

  logic [IW:0] sum;

  // staggered start: row = (core + t) mod NB
  assign sum   = {1'b0, t_i} + CORE_V;
  assign row_o = (sum >= NB_V) ? IW'(sum - NB_V) : IW'(sum);

  assign idx_a_o = IDX_W'(row_o) * IDX_W'(NB) + IDX_W'(k_i);
  assign idx_b_o = IDX_W'(k_i) * IDX_W'(NB) + IDX_W'(CORE);

  assign want_o = run_i && (|nnz_a_i) && (|nnz_b_i);
endmodule

// File: rtl/tile_sched.sv
module tile_sched
  import tile_sched_pkg::*;
#(
  parameter int NB    = 4,
  parameter int NCORE = 4,
  localparam int IW    = $clog2(NB),
  localparam int IDX_W = $clog2(NB * NB)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [NCORE-1:0]       ready_i,
  output logic [NCORE*IDX_W-1:0] md_a_idx_o,
  output logic [NCORE*IDX_W-1:0] md_b_idx_o,
  input  logic [NCORE*MD_W-1:0]  md_a_i,
  input  logic [NCORE*MD_W-1:0]  md_b_i,
  output logic [NCORE-1:0]       req_valid_o,
  output logic [NCORE*IW-1:0]    req_row_o,
  output logic [IW-1:0]          req_k_o,
  output logic [NCORE*MD_W-1:0]  req_a_md_o,
  output logic [NCORE*MD_W-1:0]  req_b_md_o,
  output logic [NCORE-1:0]       done_valid_o,
  output logic [NCORE*IW-1:0]    done_row_o,
  output logic [NCORE*IW-1:0]    done_col_o
);
  logic          run;
  logic          adv;
  logic          last_k;
  logic [IW-1:0] t_q;
  logic [IW-1:0] k_q;

  tile_step_ctr #(.NB(NB)) ctr_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .adv_i   (adv),
    .run_o   (run),
    .t_o     (t_q),
    .k_o     (k_q),
    .last_k_o(last_k)
  );

  // all engines step together so the stagger stays conflict free
  assign adv     = run && (&(~req_valid_o | ready_i));
  assign req_k_o = k_q;

  for (genvar c = 0; c < NCORE; c++) begin : g_lane
    blk_md_t       ma;
    blk_md_t       mb;
    logic [IW-1:0] row;

    assign ma = md_a_i[c*MD_W +: MD_W];
    assign mb = md_b_i[c*MD_W +: MD_W];

    tile_core_lane #(.NB(NB), .CORE(c)) lane_i (
      .run_i  (run),
      .t_i    (t_q),
      .k_i    (k_q),
      .nnz_a_i(ma.nnz),
      .nnz_b_i(mb.nnz),
      .row_o  (row),
      .idx_a_o(md_a_idx_o[c*IDX_W +: IDX_W]),
      .idx_b_o(md_b_idx_o[c*IDX_W +: IDX_W]),
      .want_o (req_valid_o[c])
    );

    assign req_row_o[c*IW +: IW]    = row;
    assign req_a_md_o[c*MD_W +: MD_W] = ma;
    assign req_b_md_o[c*MD_W +: MD_W] = mb;
    assign done_valid_o[c]          = adv && last_k;
    assign done_row_o[c*IW +: IW]   = row;
    assign done_col_o[c*IW +: IW]   = IW'(c);
  end
endmodule

// File: rtl/tile_sched_chk.sv
module tile_sched_chk
  import tile_sched_pkg::*;
#(
  parameter int NB    = 4,
  parameter int NCORE = 4,
  localparam int IW   = $clog2(NB)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NCORE-1:0]      ready_i,
  input logic [NCORE-1:0]      req_valid_o,
  input logic [NCORE*IW-1:0]   req_row_o,
  input logic [IW-1:0]         req_k_o,
  input logic [NCORE*MD_W-1:0] req_a_md_o,
  input logic [NCORE*MD_W-1:0] req_b_md_o,
  input logic [NCORE-1:0]      done_valid_o
);
  for (genvar c = 0; c < NCORE; c++) begin : g_c
    blk_md_t ma;
    blk_md_t mb;
    assign ma = req_a_md_o[c*MD_W +: MD_W];
    assign mb = req_b_md_o[c*MD_W +: MD_W];

    a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_o[c] && !ready_i[c] |=>
        $stable(req_row_o[c*IW +: IW]) && $stable(req_k_o));

    a_r7_done_last_k: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_valid_o[c] |-> req_k_o == IW'(NB - 1));

    a_r5_no_empty_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_o[c] |-> (ma.nnz != '0) && (mb.nnz != '0));

    for (genvar d = c + 1; d < NCORE; d++) begin : g_d
      a_r8_distinct_rows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_o[c] && req_valid_o[d] |->
          req_row_o[c*IW +: IW] != req_row_o[d*IW +: IW]);
    end
  end
endmodule

bind tile_sched tile_sched_chk #(.NB(NB), .NCORE(NCORE)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ready_i     (ready_i),
  .req_valid_o (req_valid_o),
  .req_row_o   (req_row_o),
  .req_k_o     (req_k_o),
  .req_a_md_o  (req_a_md_o),
  .req_b_md_o  (req_b_md_o),
  .done_valid_o(done_valid_o)
);

// File: tb/tile_sched_tb_top.sv
module tile_sched_tb_top;
  import tile_sched_pkg::*;

  localparam int NB    = 4;
  localparam int NCORE = 4;
  localparam int IW    = $clog2(NB);
  localparam int IDX_W = $clog2(NB * NB);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [NCORE-1:0] ready_i = '1;
  logic [NCORE*IDX_W-1:0] md_a_idx_o, md_b_idx_o;
  logic [NCORE*MD_W-1:0]  md_a_i, md_b_i;
  logic [NCORE-1:0]       req_valid_o, done_valid_o;
  logic [NCORE*IW-1:0]    req_row_o, done_row_o, done_col_o;
  logic [IW-1:0]          req_k_o;
  logic [NCORE*MD_W-1:0]  req_a_md_o, req_b_md_o;

  blk_md_t ta [NB*NB];
  blk_md_t tb [NB*NB];

  always #2 clk_i = ~clk_i;

  tile_sched #(.NB(NB), .NCORE(NCORE)) dut_i (.*);

  always_comb begin
    for (int c = 0; c < NCORE; c++) begin
      md_a_i[c*MD_W +: MD_W] = ta[md_a_idx_o[c*IDX_W +: IDX_W]];
      md_b_i[c*MD_W +: MD_W] = tb[md_b_idx_o[c*IDX_W +: IDX_W]];
    end
  end

  int checks = 0, errors = 0, cyc = 0;
  int m_run = 0, m_t = 0, m_k = 0;
  int done_cnt [NCORE];
  bit prev_hold [NCORE];
  int prev_row [NCORE];
  int prev_k = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic fill(int mode);
    for (int x = 0; x < NB*NB; x++) begin
      ta[x].row  = ROW_W'(16'h1000 + x);
      ta[x].size = SIZE_W'(x * 3 + 1);
      ta[x].fmt  = FMT_W'(x);
      tb[x].row  = ROW_W'(16'h2000 + x * 5);
      tb[x].size = SIZE_W'(x + 7);
      tb[x].fmt  = FMT_W'(x + 1);
      case (mode)
        0: begin ta[x].nnz = NNZ_W'(x + 1); tb[x].nnz = NNZ_W'(x + 2); end
        1: begin
          ta[x].nnz = ($urandom % 10 < 3) ? '0 : NNZ_W'($urandom % 400 + 1);
          tb[x].nnz = ($urandom % 10 < 3) ? '0 : NNZ_W'($urandom % 400 + 1);
        end
        default: begin ta[x].nnz = '0; tb[x].nnz = NNZ_W'(x + 1); end
      endcase
    end
  endtask

  task automatic step(bit st, bit rnd);
    bit ev [NCORE];
    int er [NCORE];
    bit adv;
    @(negedge clk_i);
    start_i = st;
    for (int c = 0; c < NCORE; c++) ready_i[c] = rnd ? ($urandom % 3 != 0) : 1'b1;
    #1;
    for (int c = 0; c < NCORE; c++)
      if (prev_hold[c])
        chk(int'(req_row_o[c*IW +: IW]) == prev_row[c] && int'(req_k_o) == prev_k,
            "R6", "held request moved", longint'(req_row_o[c*IW +: IW]), prev_row[c]);
    adv = (m_run != 0);
    for (int c = 0; c < NCORE; c++) begin
      int ia, ib;
      er[c] = (c + m_t) % NB;
      ia = er[c] * NB + m_k;
      ib = m_k * NB + c;
      ev[c] = (m_run != 0) && ta[ia].nnz != 0 && tb[ib].nnz != 0;
      chk(req_valid_o[c] == ev[c], "R5", "req_valid", req_valid_o[c], ev[c]);
      if (ev[c]) begin
        chk(int'(req_row_o[c*IW +: IW]) == er[c], "R3", "req_row",
            longint'(req_row_o[c*IW +: IW]), er[c]);
        chk(int'(req_k_o) == m_k, "R4", "req_k", longint'(req_k_o), m_k);
        chk(req_a_md_o[c*MD_W +: MD_W] == ta[ia], "R4", "A descriptor",
            longint'(req_a_md_o[c*MD_W +: MD_W]), longint'(ta[ia]));
        chk(req_b_md_o[c*MD_W +: MD_W] == tb[ib], "R4", "B descriptor",
            longint'(req_b_md_o[c*MD_W +: MD_W]), longint'(tb[ib]));
        if (!ready_i[c]) adv = 1'b0;
      end
    end
    for (int c = 0; c < NCORE; c++) begin
      bit ed;
      ed = adv && (m_k == NB - 1);
      chk(done_valid_o[c] == ed, "R7", "done_valid", done_valid_o[c], ed);
      if (ed) begin
        chk(int'(done_row_o[c*IW +: IW]) == er[c], "R7", "done_row",
            longint'(done_row_o[c*IW +: IW]), er[c]);
        chk(int'(done_col_o[c*IW +: IW]) == c, "R3", "done_col",
            longint'(done_col_o[c*IW +: IW]), c);
        done_cnt[c]++;
      end
      for (int d = c + 1; d < NCORE; d++)
        if (req_valid_o[c] && req_valid_o[d])
          chk(req_row_o[c*IW +: IW] != req_row_o[d*IW +: IW], "R8", "row clash",
              longint'(req_row_o[c*IW +: IW]), -1);
      prev_hold[c] = req_valid_o[c] && !ready_i[c];
      prev_row[c]  = int'(req_row_o[c*IW +: IW]);
    end
    prev_k = int'(req_k_o);
    if (m_run == 0) begin
      if (st) begin m_run = 1; m_t = 0; m_k = 0; end
    end else if (adv) begin
      if (m_k == NB - 1) begin
        m_k = 0;
        if (m_t == NB - 1) m_run = 0; else m_t++;
      end else m_k++;
    end
  endtask

  task automatic run_to_end(bit rnd, bit pulse, output int steps);
    int n = 0;
    steps = 0;
    while (m_run != 0 && n < 2000) begin
      step(pulse && (n % 5 == 2), rnd);
      steps++;
      n++;
    end
  endtask

  task automatic check_counts(string req);
    for (int c = 0; c < NCORE; c++) begin
      chk(done_cnt[c] == NB, req, "completion markers per run", done_cnt[c], NB);
      done_cnt[c] = 0;
    end
  endtask

  initial begin
    int steps;
    for (int c = 0; c < NCORE; c++) begin done_cnt[c] = 0; prev_hold[c] = 0; prev_row[c] = 0; end
    fill(0);
    #1;
    // R1: reset state
    chk(req_valid_o == '0, "R1", "req_valid in reset", longint'(req_valid_o), 0);
    chk(done_valid_o == '0, "R1", "done_valid in reset", longint'(done_valid_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) step(0, 0);
    // dense run, always ready
    step(1, 0);
    run_to_end(0, 0, steps);
    chk(steps == NB * NB, "R9", "dense run length", steps, NB * NB);
    check_counts("R9");
    repeat (3) step(0, 1);
    // sparse run, random stalls, start pulses while running are ignored (R2)
    fill(1);
    step(1, 1);
    run_to_end(1, 1, steps);
    check_counts("R2");
    repeat (2) step(0, 0);
    // all A blocks empty: nothing fetched, markers still on last k
    fill(2);
    step(1, 1);
    run_to_end(1, 0, steps);
    chk(steps == NB * NB, "R5", "empty run length", steps, NB * NB);
    check_counts("R7");
    // second sparse run with a different table
    fill(1);
    step(1, 1);
    run_to_end(1, 1, steps);
    check_counts("R9");
    repeat (3) step(0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule